// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs the external memory bus of an 8-bit processor core. One 8-bit port carries the low address byte and then the data byte, one after the other. A second 8-bit port carries the high address byte. The core hands over one request at a time. A request is a code fetch with a 16-bit program address, a data read, or a data write. A data request uses either a full 16-bit pointer or a short 8-bit address. With a short address the high port keeps showing the core's own high-port register, so software can use it as a page select.

Each external cycle runs through a fixed set of phases. First the address is put out with the address latch enable (ALE) high. ALE then falls while the address is still held, so an outside latch can capture it. Next comes a setup phase, then a strobe that stays low for a set number of clocks, then a recovery phase that raises a done pulse. The port registers go back to their resting state once the cycle ends. Two cycles can follow each other with no idle clock between them. A code fetch that stays inside on-chip program space completes in one clock and never touches the bus.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, ale is 0, code_rd_n, rd_n and wr_n are 1, lo_push is 0, lo_out and hi_out are 0xFF, req_ready is 1 and done is 0.
- R2: In the first clock after an external request is accepted, ale is 1 and lo_out carries address bits [7:0] with lo_push 1. In the next clock ale is 0 and the same address byte is still driven.
- R3: For a code fetch (req_kind 00), and for a data access with req_short 0, hi_out carries address bits [15:8] from the ALE clock through the recovery clock. The high-port register is left unchanged.
- R4: For a data access with req_short 1, hi_out shows the high-port register value for the whole cycle.
- R5: For a write (req_kind 10), the data byte is driven on lo_out (lo_push 1) one clock before wr_n falls. wr_n then stays low for STB_CYC clocks, and the data is still driven in the recovery clock after wr_n rises.
- R6: For a data read (req_kind 01 or 11) or a fetch, lo_push is 0 and lo_out is 0xFF from the setup clock to the end of the cycle. rdata takes the lo_in value that was present in the last strobe clock.
- R7: A fetch uses code_rd_n as its strobe and a data read uses rd_n. A fetch goes to the external bus when ext_sel is 1 or when the address is above 0x1FFF.
- R8: A fetch with ext_sel 0 and an address of 0x1FFF or below raises done in the next clock. ALE and all strobes stay inactive.
- R9: Every external cycle loads 0xFF into the low-port latch, replacing anything written there before. When the bus is idle, lo_out shows the latch, and a write to the latch shows up there in the next clock.
- R10: A request presented during the recovery clock starts a new ALE clock right away. If no request follows, the high-port register value comes back on hi_out in the next clock.
- R11: done is high only in the recovery clock or the internal-fetch clock, and req_ready is high whenever done is high.
- R12: At most one of ale, code_rd_n low, rd_n low and wr_n low is active in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sel | input | 1 | Forces every code fetch to the external bus |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| req_short | input | 1 | Data access uses an 8-bit address (paged) |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block can accept a request in this clock |
| done | output | 1 | Cycle completes in this clock |
| rdata | output | 8 | Last byte captured from the bus |
| hi_wr | input | 1 | Write the high-port register |
| hi_wdata | input | 8 | New high-port register value |
| lo_wr | input | 1 | Write the low-port latch |
| lo_wdata | input | 8 | New low-port latch value |
| ale | output | 1 | Address latch enable |
| code_rd_n | output | 1 | Program memory read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_out | output | 8 | Low port output value |
| lo_push | output | 1 | Low port is driven in both directions |
| lo_in | input | 8 | Low port input value |
| hi_out | output | 8 | High port output value |

## Verification
Random requests mix all four kind codes and both address forms. The random addresses fall on both sides of the 0x1FFF boundary, with ext_sel toggled. This separates an external fetch from an on-chip fetch, and an address-driven high port from a paged one. The high-port register and the low-port latch are loaded with distinct values before a cycle. This shows whether the pins carry the address or the register, and whether the latch is overwritten. Fixed cases cover fetches at 0x1FFF and 0x2000, a write followed directly by a paged read, and a latch write during idle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_LATCH,
    PH_SETUP,
    PH_STROBE,
    PH_RECOVER,
    PH_INTDONE
  } phase_e;

  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b10;

  // high port carries the address byte unless a data access is paged
  function automatic logic hi_from_addr(logic [1:0] kind, logic short_form);
    return (kind == KIND_FETCH) || !short_form;
  endfunction

  // low port is actively driven with write data after the address phase
  function automatic logic drives_data(logic [1:0] kind);
    return kind == KIND_WRITE;
  endfunction
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int STB_CYC = 2,
  parameter int CODE_LIMIT = 'h1FFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_sel,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic            req_short,
  input  logic [2*DW-1:0] req_addr,
  input  logic [DW-1:0]   req_wdata,
  output phase_e          phase,
  output logic            ready,
  output logic            accept,
  output logic            go_ext,
  output logic            strobe_last,
  output logic [1:0]      cur_kind,
  output logic            cur_short,
  output logic [2*DW-1:0] cur_addr,
  output logic [DW-1:0]   cur_wdata
);
  localparam int AW = 2 * DW;
  localparam int CW = (STB_CYC > 1) ? $clog2(STB_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STB_CYC - 1);
  localparam logic [AW-1:0] LIMIT = AW'(CODE_LIMIT);

  logic [CW-1:0] cnt;
  phase_e        nxt;
  logic          fetch_ext;

  assign ready       = (phase == PH_IDLE) || (phase == PH_RECOVER) || (phase == PH_INTDONE);
  assign accept      = req_valid && ready;
  assign fetch_ext   = ext_sel || (req_addr > LIMIT);
  assign go_ext      = accept && ((req_kind != KIND_FETCH) || fetch_ext);
  assign strobe_last = (phase == PH_STROBE) && (cnt == CNT_LAST);

  always_comb begin
    nxt = phase;
    if (accept) begin
      nxt = go_ext ? PH_ADDR : PH_INTDONE;
    end else begin
      case (phase)
        PH_ADDR:    nxt = PH_LATCH;
        PH_LATCH:   nxt = PH_SETUP;
        PH_SETUP:   nxt = PH_STROBE;
        PH_STROBE:  nxt = strobe_last ? PH_RECOVER : PH_STROBE;
        PH_RECOVER: nxt = PH_IDLE;
        PH_INTDONE: nxt = PH_IDLE;
        default:    nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      cur_kind  <= '0;
      cur_short <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else begin
      phase <= nxt;
      if (phase == PH_STROBE && !strobe_last) cnt <= cnt + 1'b1;
      else                                    cnt <= '0;
      if (accept) begin
        cur_kind  <= req_kind;
        cur_short <= req_short;
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/xbus_regs.sv
module xbus_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hi_wr,
  input  logic [DW-1:0] hi_wdata,
  input  logic          lo_wr,
  input  logic [DW-1:0] lo_wdata,
  input  logic          load_ones,
  input  logic          capture,
  input  logic [DW-1:0] lo_in,
  output logic [DW-1:0] hi_reg,
  output logic [DW-1:0] lo_latch,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_reg   <= '1;
      lo_latch <= '1;
      rdata    <= '0;
    end else begin
      if (hi_wr) hi_reg <= hi_wdata;
      if (load_ones)  lo_latch <= '1;
      else if (lo_wr) lo_latch <= lo_wdata;
      if (capture) rdata <= lo_in;
    end
  end
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  phase_e          phase,
  input  logic [1:0]      cur_kind,
  input  logic            cur_short,
  input  logic [2*DW-1:0] cur_addr,
  input  logic [DW-1:0]   cur_wdata,
  input  logic [DW-1:0]   hi_reg,
  input  logic [DW-1:0]   lo_latch,
  output logic            ale,
  output logic            code_rd_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic [DW-1:0]   lo_out,
  output logic            lo_push,
  output logic [DW-1:0]   hi_out
);
  logic in_cycle;
  logic strobing;

  assign in_cycle = (phase == PH_ADDR) || (phase == PH_LATCH) || (phase == PH_SETUP) ||
                    (phase == PH_STROBE) || (phase == PH_RECOVER);
  assign strobing = (phase == PH_STROBE);

  assign ale       = (phase == PH_ADDR);
  assign code_rd_n = !(strobing && cur_kind == KIND_FETCH);
  assign wr_n      = !(strobing && cur_kind == KIND_WRITE);
  assign rd_n      = !(strobing && cur_kind != KIND_FETCH && cur_kind != KIND_WRITE);

  assign hi_out = (in_cycle && hi_from_addr(cur_kind, cur_short)) ? cur_addr[2*DW-1:DW] : hi_reg;

  always_comb begin
    case (phase)
      PH_ADDR, PH_LATCH: begin
        lo_out  = cur_addr[DW-1:0];
        lo_push = 1'b1;
      end
      PH_SETUP, PH_STROBE, PH_RECOVER: begin
        lo_out  = drives_data(cur_kind) ? cur_wdata : '1;
        lo_push = drives_data(cur_kind);
      end
      default: begin
        lo_out  = lo_latch;
        lo_push = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int STB_CYC = 2,
  parameter int CODE_LIMIT = 'h1FFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_sel,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic            req_short,
  input  logic [2*DW-1:0] req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            req_ready,
  output logic            done,
  output logic [DW-1:0]   rdata,
  input  logic            hi_wr,
  input  logic [DW-1:0]   hi_wdata,
  input  logic            lo_wr,
  input  logic [DW-1:0]   lo_wdata,
  output logic            ale,
  output logic            code_rd_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic [DW-1:0]   lo_out,
  output logic            lo_push,
  input  logic [DW-1:0]   lo_in,
  output logic [DW-1:0]   hi_out
);
  phase_e          phase;
  logic            accept;
  logic            go_ext;
  logic            strobe_last;
  logic [1:0]      cur_kind;
  logic            cur_short;
  logic [2*DW-1:0] cur_addr;
  logic [DW-1:0]   cur_wdata;
  logic [DW-1:0]   hi_reg;
  logic [DW-1:0]   lo_latch;
  logic            capture;

  assign capture = strobe_last && !drives_data(cur_kind);
  assign done    = (phase == PH_RECOVER) || (phase == PH_INTDONE);

  xbus_seq #(.DW(DW), .STB_CYC(STB_CYC), .CODE_LIMIT(CODE_LIMIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .req_valid(req_valid),
    .req_kind(req_kind), .req_short(req_short), .req_addr(req_addr),
    .req_wdata(req_wdata), .phase(phase), .ready(req_ready), .accept(accept),
    .go_ext(go_ext), .strobe_last(strobe_last), .cur_kind(cur_kind),
    .cur_short(cur_short), .cur_addr(cur_addr), .cur_wdata(cur_wdata)
  );

  xbus_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .hi_wr(hi_wr), .hi_wdata(hi_wdata),
    .lo_wr(lo_wr), .lo_wdata(lo_wdata), .load_ones(go_ext), .capture(capture),
    .lo_in(lo_in), .hi_reg(hi_reg), .lo_latch(lo_latch), .rdata(rdata)
  );

  xbus_pins #(.DW(DW)) u_pins (
    .phase(phase), .cur_kind(cur_kind), .cur_short(cur_short), .cur_addr(cur_addr),
    .cur_wdata(cur_wdata), .hi_reg(hi_reg), .lo_latch(lo_latch), .ale(ale),
    .code_rd_n(code_rd_n), .rd_n(rd_n), .wr_n(wr_n), .lo_out(lo_out),
    .lo_push(lo_push), .hi_out(hi_out)
  );
endmodule

// File: rtl/xbus_chk.sv
module xbus_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ale,
  input logic          code_rd_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic [DW-1:0] lo_out,
  input logic          lo_push,
  input logic          done,
  input logic          req_ready,
  input logic          accept,
  input logic          go_ext
);
  assert_ale_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale);
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (lo_push && $stable(lo_out)));
  assert_wr_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> (lo_push && $stable(lo_out)));
  assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (lo_push && $stable(lo_out)));
  assert_rd_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !code_rd_n) |-> !lo_push);
  assert_int_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !go_ext) |=> (done && !ale));
  assert_done_ready_R11: assert property (@(posedge clk) disable iff (!rst_n) done |-> req_ready);
  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ale, !rd_n, !wr_n, !code_rd_n}) <= 1);
endmodule

bind xbus_ctrl xbus_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .code_rd_n(code_rd_n), .rd_n(rd_n),
  .wr_n(wr_n), .lo_out(lo_out), .lo_push(lo_push), .done(done),
  .req_ready(req_ready), .accept(accept), .go_ext(go_ext)
);

// File: tb/tb_xbus_ctrl.sv
module tb_xbus_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int STB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_sel = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic        req_short = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, done;
  logic [7:0]  rdata;
  logic        hi_wr = 1'b0;
  logic [7:0]  hi_wdata = '0;
  logic        lo_wr = 1'b0;
  logic [7:0]  lo_wdata = '0;
  logic        ale, code_rd_n, rd_n, wr_n, lo_push;
  logic [7:0]  lo_out, hi_out;
  logic [7:0]  lo_in = '0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] m_hi = 8'hFF;
  logic [7:0] m_lo = 8'hFF;
  bit         nxt_go = 0;
  logic [1:0] nxt_kind;
  logic       nxt_short;
  logic [15:0] nxt_addr;
  logic [7:0] nxt_wdata;

  xbus_ctrl #(.STB_CYC(STB)) dut (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .req_valid(req_valid),
    .req_kind(req_kind), .req_short(req_short), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rdata(rdata),
    .hi_wr(hi_wr), .hi_wdata(hi_wdata), .lo_wr(lo_wr), .lo_wdata(lo_wdata),
    .ale(ale), .code_rd_n(code_rd_n), .rd_n(rd_n), .wr_n(wr_n), .lo_out(lo_out),
    .lo_push(lo_push), .lo_in(lo_in), .hi_out(hi_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
      report();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit is_external(logic [1:0] k, logic es, logic [15:0] a);
    return (k != 2'b00) || es || (a > 16'h1FFF);
  endfunction

  function automatic logic [7:0] exp_hi(logic [1:0] k, logic s, logic [15:0] a, logic [7:0] reg_v);
    if (k == 2'b00 || !s) return a[15:8];
    return reg_v;
  endfunction

  // {ale, code_rd_n, rd_n, wr_n} expected while strobing
  function automatic logic [3:0] exp_strobes(logic [1:0] k);
    case (k)
      2'b00:   return 4'b0011;
      2'b10:   return 4'b0110;
      default: return 4'b0101;
    endcase
  endfunction

  task automatic issue(input logic [1:0] k, input logic s, input logic [15:0] a, input logic [7:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_short = s; req_addr = a; req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic write_hi(input logic [7:0] v);
    @(negedge clk); hi_wr = 1'b1; hi_wdata = v;
    @(posedge clk); #1; hi_wr = 1'b0; m_hi = v;
  endtask

  task automatic write_lo(input logic [7:0] v);
    @(negedge clk); lo_wr = 1'b1; lo_wdata = v;
    @(posedge clk); #1; lo_wr = 1'b0; m_lo = v;
  endtask

  // walk one external cycle after its acceptance edge
  task automatic walk(input logic [1:0] k, input logic s, input logic [15:0] a,
                      input logic [7:0] wd, input logic [7:0] rv);
    logic [7:0] eh;
    bit wr;
    eh = exp_hi(k, s, a, m_hi);
    wr = (k == 2'b10);
    @(negedge clk);
    chk("R2 ale high", ale, 1);
    chk("R2 addr low", lo_out, a[7:0]);
    chk("R2 push", lo_push, 1);
    chk(s && k != 2'b00 ? "R4 hi page" : "R3 hi addr", hi_out, eh);
    @(negedge clk);
    chk("R2 ale low", ale, 0);
    chk("R2 addr held", lo_out, a[7:0]);
    @(negedge clk);
    chk("R5 R6 setup lo", lo_out, wr ? wd : 8'hFF);
    chk("R5 R6 setup push", lo_push, wr);
    chk("R12 no strobe in setup", {ale, code_rd_n, rd_n, wr_n}, 4'b0111);
    lo_in = rv;
    for (int i = 0; i < STB; i++) begin
      @(negedge clk);
      chk("R7 R5 R6 strobe", {ale, code_rd_n, rd_n, wr_n}, exp_strobes(k));
      chk("R5 R6 strobe lo", lo_out, wr ? wd : 8'hFF);
      chk("R3 R4 hi strobe", hi_out, eh);
    end
    @(negedge clk);
    chk("R11 done", done, 1);
    chk("R11 ready", req_ready, 1);
    chk("R5 strobes off", {ale, code_rd_n, rd_n, wr_n}, 4'b0111);
    chk("R5 R6 recover lo", lo_out, wr ? wd : 8'hFF);
    chk("R3 R4 hi recover", hi_out, eh);
    if (!wr) chk("R6 rdata", rdata, rv);
    lo_in = ~rv;
    m_lo = 8'hFF;
    if (nxt_go) begin
      req_valid = 1'b1; req_kind = nxt_kind; req_short = nxt_short;
      req_addr = nxt_addr; req_wdata = nxt_wdata;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    nxt_go = 0;
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    chk({tag, " R10 hi restored"}, hi_out, m_hi);
    chk({tag, " R9 lo latch"}, lo_out, m_lo);
    chk({tag, " R11 no done"}, done, 0);
    chk({tag, " R9 idle push"}, lo_push, 0);
  endtask

  task automatic internal_fetch(input logic [15:0] a);
    issue(2'b00, 1'b0, a, 8'h00);
    @(negedge clk);
    chk("R8 done", done, 1);
    chk("R8 no bus", {ale, code_rd_n, rd_n, wr_n}, 4'b0111);
    chk("R8 hi", hi_out, m_hi);
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'h5EED);
    #(3 * CLK_PERIOD + 2);
    // R1 reset state
    chk("R1 ale", ale, 0);
    chk("R1 strobes", {code_rd_n, rd_n, wr_n}, 3'b111);
    chk("R1 push", lo_push, 0);
    chk("R1 lo", lo_out, 8'hFF);
    chk("R1 hi", hi_out, 8'hFF);
    chk("R1 ready", req_ready, 1);
    chk("R1 done", done, 0);
    rst_n = 1'b1;

    // R9 latch write visible, then overwritten by a cycle
    write_lo(8'h5A);
    check_idle("lo write");
    write_hi(8'h3C);
    issue(2'b10, 1'b0, 16'hA155, 8'hC3);
    walk(2'b10, 1'b0, 16'hA155, 8'hC3, 8'h00);
    check_idle("after write");

    // R7 boundary: 0x1FFF internal, 0x2000 external
    internal_fetch(16'h1FFF);
    check_idle("int fetch");
    issue(2'b00, 1'b1, 16'h2000, 8'h00);
    walk(2'b00, 1'b1, 16'h2000, 8'h00, 8'h9E);
    check_idle("fetch 2000");
    ext_sel = 1'b1;
    issue(2'b00, 1'b0, 16'h0012, 8'h00);
    walk(2'b00, 1'b0, 16'h0012, 8'h00, 8'h71);
    ext_sel = 1'b0;

    // R10 back-to-back: wide write then paged read
    write_lo(8'h11);
    write_hi(8'h42);
    nxt_go = 1; nxt_kind = 2'b01; nxt_short = 1'b1; nxt_addr = 16'h77E0; nxt_wdata = 8'h00;
    issue(2'b10, 1'b0, 16'hBEEF, 8'hD4);
    walk(2'b10, 1'b0, 16'hBEEF, 8'hD4, 8'h00);
    walk(2'b01, 1'b1, 16'h77E0, 8'h00, 8'h2B);
    check_idle("after chain");

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [1:0]  k;
      logic        s;
      logic [15:0] a;
      logic [7:0]  wd, rv;
      k  = 2'($urandom_range(0, 3));
      s  = 1'($urandom_range(0, 1));
      a  = (($urandom_range(0, 1) == 1) ? 16'($urandom_range(0, 16'h1FFF)) : 16'($urandom));
      wd = 8'($urandom); rv = 8'($urandom);
      ext_sel = 1'($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 2) == 0) write_hi(8'($urandom));
      if ($urandom_range(0, 2) == 0) write_lo(8'($urandom));
      if (is_external(k, ext_sel, a)) begin
        issue(k, s, a, wd);
        walk(k, s, a, wd, rv);
      end else begin
        internal_fetch(a);
      end
      check_idle("random");
    end
    report();
  end
endmodule